// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block gives a 64-bit core a pair of synchronising memory operations. A load-linked request forms an effective address, reads word or doubleword data from a single-port memory, returns that data for the destination register, and keeps both the address and the returned value as a reservation. A later store-conditional request succeeds only when its address equals the reserved address *and* the memory still holds the reserved value. The unit checks this with a locked read followed by a locked write, so it acts as a value-checked compare-and-swap and not as a monitor flag that snooping clears.

Requests arrive one at a time over a valid/ready handshake. Each accepted request ends with a single-cycle `done` pulse that carries the register number, a write enable and the 64-bit result. The memory side uses a request/acknowledge protocol. A request is held until it is acknowledged, and read data is valid in the acknowledge cycle. A lock output marks the two accesses of a compare-and-swap as indivisible.

Top module: `llsc_unit`

## Requirements
- R1: The effective address is `req_base` plus the 14-bit signed `req_imm` shifted left by two bits, and it appears on `mem_addr` for every memory access of the request.
- R2: A word load-linked (`req_dword`=0) returns the low 32 bits of `mem_rdata` sign-extended to 64 bits and ignores the upper 32 bits. A doubleword load-linked (`req_dword`=1) returns all 64 bits.
- R3: A load-linked (`req_op`=0) to a nonzero register completes with `done_we`=1 and `done_data` equal to the loaded value, makes exactly one memory read, and records address and value as the new reservation.
- R4: A load-linked to register 0 makes no memory access, completes with `done_we`=0 and `done_data`=0, and leaves the existing reservation untouched.
- R5: A store-conditional (`req_op`=1) whose address differs from the reserved address makes no memory access and returns 0.
- R6: A store-conditional at the reserved address that reads a value equal to the reserved value writes `req_src` (only its low 32 bits for a word), makes exactly two accesses and returns 1.
- R7: A store-conditional at the reserved address that reads a value different from the reserved value makes no write, leaves memory unchanged and returns 0.
- R8: Every memory write is issued with `mem_lock` high. The lock stays high with no gap from the compare read through the write, and it is low during load-linked accesses.
- R9: Reset leaves the reservation invalid, so a store-conditional with no load-linked since reset fails with no memory access, even at address 0 against zero data.
- R10: `req_ready` is high only while idle. Each accepted request produces exactly one single-cycle `done` pulse naming its destination register, and `req_ready` returns in the cycle after that pulse. After reset, `req_ready`=1 and `done`=0.
- R11: Once `mem_req` is raised, it and `mem_addr`/`mem_we` stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and accepting |
| req_op | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_rd | input | 5 | Destination register number |
| req_base | input | 64 | Base register value |
| req_imm | input | 14 | Signed word-scaled offset |
| req_src | input | 64 | Old destination contents (store data) |
| done | output | 1 | One-cycle completion pulse |
| done_rd | output | 5 | Register to update |
| done_we | output | 1 | Register write enable |
| done_data | output | 64 | Result for the register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Hold off other requesters |
| mem_dword | output | 1 | Access size, 1 = 64-bit |
| mem_addr | output | 64 | Access byte address |
| mem_wdata | output | 64 | Write data (low half for word) |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 64 | Read data, valid with mem_ack |

## Verification
On every cycle the assertions check the protocol side: a write is never unlocked, a write always follows a locked cycle, requests hold steady until acknowledged, `done` lasts one cycle and the unit stops accepting once busy. Whether a result is right depends on history. Examples are sign extension, the address arithmetic, a reservation that a register-0 load leaves alone, a compare that fails after the bench alters memory between the two operations, and the invalid reservation after reset. Only the bench scenarios show these, by following a chain of requests against its memory model and counting the accesses of each request.

// File: rtl/llsc_pkg.sv
// Shared types for the load-linked / store-conditional unit.
// Assumes one request in flight at a time.
package llsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL_RD,
        ST_SC_RD,
        ST_SC_WR,
        ST_RESP
    } llsc_state_t;

    typedef enum logic {
        OP_LL = 1'b0,
        OP_SC = 1'b1
    } llsc_op_t;

endpackage

// File: rtl/llsc_agen.sv
// Effective address generator: base plus signed immediate scaled by
// 2**SHIFT. Purely combinational; assumes XLEN > IMM_W + SHIFT.
module llsc_agen #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 14,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  ea
);
    localparam int EXT_W = XLEN - IMM_W - SHIFT;

    logic [XLEN-1:0] offset;

    // Sign-extend and scale the immediate, then add it to the base.
    always_comb begin
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
        ea     = base + offset;
    end
endmodule

// File: rtl/llsc_ext.sv
// Read-data formatter: passes a full doubleword, or sign-extends the low
// half for a word access. Upper half of the bus is ignored for words.
module llsc_ext #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rdata,
    input  logic            dword,
    output logic [XLEN-1:0] value
);
    localparam int HALF = XLEN / 2;

    // Select full width or sign-extended low half.
    always_comb begin
        if (dword) begin
            value = rdata;
        end else begin
            value = {{HALF{rdata[HALF-1]}}, rdata[HALF-1:0]};
        end
    end
endmodule

// File: rtl/llsc_resv.sv
// Reservation store: holds the address and value captured by the last
// load-linked. Invalid after reset. Reports an address hit for the
// address offered on chk_addr.
module llsc_resv #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [XLEN-1:0] set_addr,
    input  logic [XLEN-1:0] set_val,
    input  logic [XLEN-1:0] chk_addr,
    output logic            hit,
    output logic [XLEN-1:0] val
);
    logic            r_valid;
    logic [XLEN-1:0] r_addr;
    logic [XLEN-1:0] r_val;

    // Capture a new reservation; reset drops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_valid <= 1'b0;
            r_addr  <= '0;
            r_val   <= '0;
        end else if (set_en) begin
            r_valid <= 1'b1;
            r_addr  <= set_addr;
            r_val   <= set_val;
        end
    end

    // Address hit only counts while a reservation exists.
    always_comb begin
        hit = r_valid && (chk_addr == r_addr);
        val = r_val;
    end
endmodule

// File: rtl/llsc_ctrl.sv
// Sequencer for one request at a time: accepts, runs the load or the
// locked compare-and-swap, then raises done for one cycle.
// Assumes mem_ack arrives only while mem_req is high.
module llsc_ctrl
    import llsc_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic             req_dword,
    input  logic [REG_W-1:0] req_rd,
    input  logic [XLEN-1:0]  req_src,
    input  logic [XLEN-1:0]  ea,
    input  logic             resv_hit,
    input  logic [XLEN-1:0]  resv_val,
    input  logic [XLEN-1:0]  rd_value,
    input  logic             mem_ack,
    output logic             req_ready,
    output logic             done,
    output logic [REG_W-1:0] done_rd,
    output logic             done_we,
    output logic [XLEN-1:0]  done_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_lock,
    output logic             mem_dword,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             resv_set
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    llsc_state_t      st;
    logic             q_dword;
    logic [REG_W-1:0] q_rd;
    logic             q_we;
    logic [XLEN-1:0]  q_addr;
    logic [XLEN-1:0]  q_src;
    logic [XLEN-1:0]  q_res;

    // State machine and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            q_dword <= 1'b0;
            q_rd    <= '0;
            q_we    <= 1'b0;
            q_addr  <= '0;
            q_src   <= '0;
            q_res   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_dword <= req_dword;
                        q_rd    <= req_rd;
                        q_we    <= (req_rd != '0);
                        q_addr  <= ea;
                        q_src   <= req_src;
                        q_res   <= '0;
                        if (req_op == OP_LL) begin
                            st <= (req_rd != '0) ? ST_LL_RD : ST_RESP;
                        end else begin
                            st <= resv_hit ? ST_SC_RD : ST_RESP;
                        end
                    end
                end
                ST_LL_RD: begin
                    if (mem_ack) begin
                        q_res <= rd_value;
                        st    <= ST_RESP;
                    end
                end
                ST_SC_RD: begin
                    if (mem_ack) begin
                        if (rd_value == resv_val) begin
                            q_res <= ONE;
                            st    <= ST_SC_WR;
                        end else begin
                            st    <= ST_RESP;
                        end
                    end
                end
                ST_SC_WR: begin
                    if (mem_ack) begin
                        st <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    st <= ST_IDLE;
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    // Decode outputs from the current state and captured request.
    always_comb begin
        req_ready = (st == ST_IDLE);
        done      = (st == ST_RESP);
        done_rd   = q_rd;
        done_we   = q_we;
        done_data = q_res;
        mem_req   = (st == ST_LL_RD) || (st == ST_SC_RD) || (st == ST_SC_WR);
        mem_we    = (st == ST_SC_WR);
        mem_lock  = (st == ST_SC_RD) || (st == ST_SC_WR);
        mem_dword = q_dword;
        mem_addr  = q_addr;
        mem_wdata = q_src;
        resv_set  = (st == ST_LL_RD) && mem_ack;
    end
endmodule

// File: rtl/llsc_unit.sv
// Top of the load-linked / store-conditional unit. Wires the address
// generator, read formatter, reservation store and sequencer.
// Assumes a memory that holds off other requesters while mem_lock is high.
module llsc_unit #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 14,
    parameter int SHIFT = 2,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_op,
    input  logic             req_dword,
    input  logic [REG_W-1:0] req_rd,
    input  logic [XLEN-1:0]  req_base,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [XLEN-1:0]  req_src,
    output logic             done,
    output logic [REG_W-1:0] done_rd,
    output logic             done_we,
    output logic [XLEN-1:0]  done_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_lock,
    output logic             mem_dword,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [XLEN-1:0]  mem_rdata
);
    logic [XLEN-1:0] ea;
    logic [XLEN-1:0] rd_value;
    logic [XLEN-1:0] resv_val;
    logic            resv_hit;
    logic            resv_set;

    llsc_agen #(.XLEN(XLEN), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_agen (
        .base (req_base),
        .imm  (req_imm),
        .ea   (ea)
    );

    llsc_ext #(.XLEN(XLEN)) u_ext (
        .rdata (mem_rdata),
        .dword (mem_dword),
        .value (rd_value)
    );

    llsc_resv #(.XLEN(XLEN)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (resv_set),
        .set_addr (mem_addr),
        .set_val  (rd_value),
        .chk_addr (ea),
        .hit      (resv_hit),
        .val      (resv_val)
    );

    llsc_ctrl #(.XLEN(XLEN), .REG_W(REG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_dword (req_dword),
        .req_rd    (req_rd),
        .req_src   (req_src),
        .ea        (ea),
        .resv_hit  (resv_hit),
        .resv_val  (resv_val),
        .rd_value  (rd_value),
        .mem_ack   (mem_ack),
        .req_ready (req_ready),
        .done      (done),
        .done_rd   (done_rd),
        .done_we   (done_we),
        .done_data (done_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_lock  (mem_lock),
        .mem_dword (mem_dword),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .resv_set  (resv_set)
    );
endmodule

// File: rtl/llsc_unit_chk.sv
// Protocol checker for llsc_unit, attached with bind. Observes ports only.
module llsc_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            done,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_lock,
    input logic            mem_ack,
    input logic [XLEN-1:0] mem_addr
);
    // R8: no write leaves the unit without the lock.
    p_write_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_lock);

    // R8: a write always follows a locked cycle (the compare read).
    p_lock_before_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_lock));

    // R11: an unacknowledged request holds steady.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10: done is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an accepted request makes the unit busy.
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: no acceptance in the completion cycle.
    p_done_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
endmodule

bind llsc_unit llsc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/llsc_unit_test.sv
`timescale 1ns/1ps
// Bench for llsc_unit: vector table walked by one loop, then directed
// tests for interference, reset and protocol stability.
module llsc_unit_test;
    typedef struct packed {
        logic        op;
        logic        dw;
        logic [4:0]  rd;
        logic [63:0] base;
        logic [13:0] imm;
        logic [63:0] src;
        logic        ew;
        logic [63:0] ed;
        logic [1:0]  acc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 1'b1, 5'd5,  64'h1000, 14'h0002, 64'h0,                  1'b1, 64'h12345601_87654301, 2'd1},
        '{1'b1, 1'b1, 5'd6,  64'h1000, 14'h0002, 64'hAAAA5555_AAAA5555,  1'b1, 64'h1,                 2'd2},
        '{1'b1, 1'b1, 5'd6,  64'h1000, 14'h0002, 64'h1,                  1'b1, 64'h0,                 2'd1},
        '{1'b0, 1'b0, 5'd7,  64'h1010, 14'h3FFC, 64'h0,                  1'b1, 64'hFFFFFFFF_87654300, 2'd1},
        '{1'b0, 1'b0, 5'd7,  64'h1000, 14'h0001, 64'h0,                  1'b1, 64'h00000000_12345600, 2'd1},
        '{1'b1, 1'b0, 5'd8,  64'h1008, 14'h3FFF, 64'hFFFFFFFF_0BADF00D,  1'b1, 64'h1,                 2'd2},
        '{1'b1, 1'b0, 5'd8,  64'h1000, 14'h0000, 64'h2,                  1'b1, 64'h0,                 2'd0},
        '{1'b0, 1'b1, 5'd9,  64'h1000, 14'h0004, 64'h0,                  1'b1, 64'h12345602_87654302, 2'd1},
        '{1'b0, 1'b1, 5'd0,  64'h1000, 14'h0006, 64'h0,                  1'b0, 64'h0,                 2'd0},
        '{1'b1, 1'b1, 5'd10, 64'h1010, 14'h0000, 64'h01234567_89ABCDEF,  1'b1, 64'h1,                 2'd2},
        '{1'b1, 1'b1, 5'd0,  64'h1010, 14'h0000, 64'h5,                  1'b0, 64'h0,                 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic        req_dword = 1'b0;
    logic [4:0]  req_rd = '0;
    logic [63:0] req_base = '0;
    logic [13:0] req_imm = '0;
    logic [63:0] req_src = '0;
    logic        done;
    logic [4:0]  done_rd;
    logic        done_we;
    logic [63:0] done_data;
    logic        mem_req, mem_we, mem_lock, mem_dword;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [63:0] mem_rdata;

    logic [63:0] mem [0:15];
    logic        poke_en = 1'b0;
    logic [3:0]  poke_idx = '0;
    logic [63:0] poke_val = '0;

    int nchk = 0;
    int nfail = 0;
    int acc_tot = 0, lock_tot = 0, nolock_tot = 0, hold_viol = 0;
    logic [63:0] last_addr = '0;
    logic        prev_pend = 1'b0;
    logic [63:0] prev_addr = '0;

    always #10 clk = ~clk;

    llsc_unit uut (.*);

    // Memory model: one-cycle acknowledge, word halves selected by addr[2].
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                mem[i] <= {32'h12345600 + 32'(i), 32'h87654300 + 32'(i)};
            end
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            if (poke_en) mem[poke_idx] <= poke_val;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    if (mem_dword) mem[mem_addr[6:3]] <= mem_wdata;
                    else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
                    else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
                end else begin
                    if (mem_dword) mem_rdata <= mem[mem_addr[6:3]];
                    else if (mem_addr[2]) mem_rdata <= {32'hDEADBEEF, mem[mem_addr[6:3]][63:32]};
                    else mem_rdata <= {32'hDEADBEEF, mem[mem_addr[6:3]][31:0]};
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // Port monitor sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_ack) acc_tot <= acc_tot + 1;
            if (mem_req) last_addr <= mem_addr;
            if (!req_ready && !done && mem_lock) lock_tot <= lock_tot + 1;
            if (!req_ready && !done && !mem_lock) nolock_tot <= nolock_tot + 1;
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
            prev_pend <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
        end else begin
            prev_pend <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic poke(input logic [3:0] idx, input logic [63:0] val);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = idx; poke_val = val;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // Issue one request; return result and per-request monitor deltas.
    task automatic issue(input logic op, input logic dw, input logic [4:0] rd,
                         input logic [63:0] base, input logic [13:0] imm, input logic [63:0] src,
                         output logic we, output logic [63:0] data, output logic [4:0] drd,
                         output int acc, output int lk, output int nlk);
        int a0, l0, n0, guard;
        @(negedge clk);
        a0 = acc_tot; l0 = lock_tot; n0 = nolock_tot;
        req_valid = 1'b1; req_op = op; req_dword = dw; req_rd = rd;
        req_base = base; req_imm = imm; req_src = src;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        we = done_we; data = done_data; drd = done_rd;
        @(negedge clk);
        acc = acc_tot - a0; lk = lock_tot - l0; nlk = nolock_tot - n0;
        chk(!done && req_ready, "R10 done pulse width", {62'b0, done, req_ready}, 64'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic we;
        logic [63:0] data;
        logic [4:0] drd;
        int acc, lk, nlk;
        logic [63:0] ea;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !mem_req, "R10 reset state",
            {61'b0, req_ready, done, mem_req}, 64'h4);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].dw, VECS[i].rd, VECS[i].base, VECS[i].imm,
                  VECS[i].src, we, data, drd, acc, lk, nlk);
            chk(we == VECS[i].ew, VECS[i].op ? "R5/R6/R7 write enable" : "R3/R4 write enable",
                64'(we), 64'(VECS[i].ew));
            chk(data == VECS[i].ed, VECS[i].op ? "R5/R6/R7 result" : "R2/R3/R4 result",
                data, VECS[i].ed);
            chk(drd == VECS[i].rd, "R10 done_rd", 64'(drd), 64'(VECS[i].rd));
            chk(acc == int'(VECS[i].acc), "R3/R4/R5/R6/R7 access count",
                64'(acc), 64'(VECS[i].acc));
            if (VECS[i].op) begin
                chk(nlk == 0, "R8 lock gap in compare-and-swap", 64'(nlk), 64'h0);
            end else begin
                chk(lk == 0, "R8 lock during load", 64'(lk), 64'h0);
            end
            if (VECS[i].acc != 0) begin
                ea = VECS[i].base + {{48{VECS[i].imm[13]}}, VECS[i].imm, 2'b00};
                chk(last_addr == ea, "R1 effective address", last_addr, ea);
            end
        end

        chk(mem[1] == 64'hAAAA5555_AAAA5555, "R6 doubleword store", mem[1], 64'hAAAA5555_AAAA5555);
        chk(mem[0] == 64'h0BADF00D_87654300, "R6 word store into upper half", mem[0], 64'h0BADF00D_87654300);
        chk(mem[2] == 64'h01234567_89ABCDEF, "R4 reservation kept over register-0 load",
            mem[2], 64'h01234567_89ABCDEF);

        // R7: memory altered between the two operations.
        issue(1'b0, 1'b1, 5'd3, 64'h1000, 14'h0006, 64'h0, we, data, drd, acc, lk, nlk);
        chk(data == 64'h12345603_87654303, "R3 load before interference", data, 64'h12345603_87654303);
        poke(4'd3, 64'h55);
        issue(1'b1, 1'b1, 5'd4, 64'h1000, 14'h0006, 64'h99, we, data, drd, acc, lk, nlk);
        chk(data == 64'h0 && acc == 1, "R7 changed value fails", data, 64'h0);
        chk(mem[3] == 64'h55, "R7 memory untouched", mem[3], 64'h55);

        // R9: reset drops the reservation.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !mem_req, "R10 state after second reset",
            {61'b0, req_ready, done, mem_req}, 64'h4);
        poke(4'd0, 64'h0);
        issue(1'b1, 1'b1, 5'd4, 64'h0, 14'h0000, 64'h77, we, data, drd, acc, lk, nlk);
        chk(data == 64'h0 && we, "R9 store-conditional after reset fails", data, 64'h0);
        chk(acc == 0, "R9 no access after reset", 64'(acc), 64'h0);
        chk(mem[0] == 64'h0, "R9 memory untouched", mem[0], 64'h0);

        chk(hold_viol == 0, "R11 request stable until ack", 64'(hold_viol), 64'h0);

        summary();
        $finish;
    end
endmodule